// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Event Interrupts

This block is a watchdog built around a free-running up-counter that advances on a slow tick. The tick is an enable pulse on the fast register clock, and it can be divided by a programmable power-of-two prescaler. Software services the watchdog through a simple register port with an address, a write strobe, write data and registered read data. It reloads the counter by writing a new value to a trigger register. It starts and stops the timer with two-word unlock sequences. A load value set by software is copied into the counter only when the counter is reloaded or overflows.

When the counter wraps past its all-ones value, the block pulls an active-low reset output low for a fixed number of clocks and records an overflow event. A second event records the tick on which the counter lands on a programmed delay value. The two events share one active-low interrupt line. Each event has its own enable, which is set and cleared through separate registers.

Word addresses: 0 control, 1 counter, 2 load, 3 trigger, 4 run sequence, 5 delay, 6 event status, 7 enable-set, 8 enable-clear. Read data appears one clock after the address is presented.

Top module: `wdog_timer`

## Requirements
- R1: After reset the counter reads 0, the timer is running (run-sequence register reads 1), status and enables read 0, and both `wdt_rst_n` and `irq_n` are high.
- R2: With the prescaler disabled, each `tick_en` pulse while running adds exactly one to the counter, and the value can be read back while it counts.
- R3: Control bit 5 enables the prescaler and bits [4:2] hold a field k. With the bit set, the counter advances once per 2^k ticks; with it clear, it advances once per tick. Writing control restarts the division.
- R4: Writing the load register leaves the running counter unchanged.
- R5: A trigger write whose value differs from the previous trigger value copies the load value into the counter. Repeating the previous value has no effect.
- R6: A tick at count 0xFFFFFFFF loads the counter from the load register and sets status bit 0.
- R7: After an overflow, `wdt_rst_n` stays low for exactly RST_CYC clocks (16 by default).
- R8: Status bit 1 sets on the tick that brings the counter to the delay register value.
- R9: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R10: Writing 1 to an enable bit through enable-set sets that bit, and writing 1 through enable-clear clears it. Zero bits have no effect. Bit 0 enables overflow and bit 1 enables delay. Both addresses read back the enables.
- R11: `irq_n` is low exactly when some status bit and its enable are both set, and it follows in the same cycle those registers change.
- R12: Writing 0xAAAA then 0x5555 to the run-sequence register stops the counter, so ticks are ignored. Writing 0xBBBB then 0x4444 restarts it. A wrong second word abandons the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle slow counting tick |
| addr | input | ADDR_W | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wdt_rst_n | output | 1 | Active-low watchdog reset pulse |
| irq_n | output | 1 | Active-low event interrupt |

## Verification
The assertions assume that `tick_en` is a single-cycle pulse synchronous to `clk`, and that a write is a one-cycle strobe carrying one address. They also assume that the run-sequence words arrive as consecutive writes to that register. The stimulus follows these rules: it raises each tick for one cycle with an idle cycle after it, and it never overlaps a write with a tick. Every counter, status and reset-pulse outcome therefore has a single cycle in which it is expected.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_EV = 2;
  localparam int EV_OVF = 0;
  localparam int EV_DLY = 1;

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_COUNT  = 4'd1,
    RA_LOAD   = 4'd2,
    RA_TRIG   = 4'd3,
    RA_RUN    = 4'd4,
    RA_DELAY  = 4'd5,
    RA_STAT   = 4'd6,
    RA_IENSET = 4'd7,
    RA_IENCLR = 4'd8
  } wdog_addr_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_STOP  = 2'd2
  } seq_state_e;

  localparam logic [DATA_W-1:0] KEY_START_A = 32'h0000_BBBB;
  localparam logic [DATA_W-1:0] KEY_START_B = 32'h0000_4444;
  localparam logic [DATA_W-1:0] KEY_STOP_A  = 32'h0000_AAAA;
  localparam logic [DATA_W-1:0] KEY_STOP_B  = 32'h0000_5555;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             run,
  input  logic             clr,
  input  logic             pre_en,
  input  logic [PRE_W-1:0] ratio,
  output logic             cnt_tick
);
  localparam int DIV_W = (2 ** PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;
  logic             live;

  always_comb begin
    limit    = (DIV_W'(1) << ratio) - DIV_W'(1);
    live     = tick_en && run;
    cnt_tick = pre_en ? (live && (div_q == limit)) : live;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (live && pre_en) begin
      div_q <= (div_q == limit) ? '0 : div_q + DIV_W'(1);
    end
  end

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
    cnt_tick |-> (tick_en && run)); // R3
endmodule

// File: rtl/wdog_runctl.sv
module wdog_runctl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              running
);
  seq_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      running <= 1'b1;
    end else if (run_we) begin
      case (st_q)
        SQ_IDLE: begin
          if (wdata == KEY_START_A)     st_q <= SQ_START;
          else if (wdata == KEY_STOP_A) st_q <= SQ_STOP;
        end
        SQ_START: begin
          if (wdata == KEY_START_B) running <= 1'b1;
          st_q <= SQ_IDLE;
        end
        SQ_STOP: begin
          if (wdata == KEY_STOP_B) running <= 1'b0;
          st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_RUN_BY_SEQ: assert property (@(posedge clk) disable iff (rst)
    !$stable(running) |-> ($past(run_we) && $past(st_q) != SQ_IDLE)); // R12
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic             load_we,
  input  logic             trig_we,
  input  logic             delay_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] delay_q,
  output logic [CNT_W-1:0] trig_q,
  output logic             reload,
  output logic             ovf_ev,
  output logic             dly_ev
);
  logic             wrap;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    reload  = trig_we && (wdata != trig_q);
    wrap    = (count_q == '1);
    cnt_nxt = wrap ? load_q : count_q + CNT_W'(1);
    ovf_ev  = cnt_tick && !reload && wrap;
    dly_ev  = cnt_tick && !reload && (cnt_nxt == delay_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      load_q  <= '0;
      delay_q <= '0;
      trig_q  <= '0;
    end else begin
      if (load_we)  load_q  <= wdata;
      if (delay_we) delay_q <= wdata;
      if (trig_we)  trig_q  <= wdata;
      if (reload)        count_q <= load_q;
      else if (cnt_tick) count_q <= cnt_nxt;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && !reload && !wrap) |=> count_q == $past(count_q) + CNT_W'(1)); // R2
  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> count_q == $past(load_q)); // R6
  AST_TRIG_SAME: assert property (@(posedge clk) disable iff (rst)
    (trig_we && wdata == trig_q && !cnt_tick) |=> $stable(count_q)); // R5
  AST_LOAD_NO_FLY: assert property (@(posedge clk) disable iff (rst)
    (load_we && !trig_we && !cnt_tick) |=> $stable(count_q)); // R4
endmodule

// File: rtl/wdog_irq.sv
module wdog_irq
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev,
  input  logic              stat_we,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [NUM_EV-1:0] wbits,
  output logic [NUM_EV-1:0] stat_q,
  output logic [NUM_EV-1:0] ien_q,
  output logic              irq_n
);
  logic [NUM_EV-1:0] stat_nxt;
  logic [NUM_EV-1:0] ien_nxt;

  always_comb begin
    stat_nxt = stat_q;
    if (stat_we) stat_nxt = stat_nxt & ~wbits;
    stat_nxt = stat_nxt | ev;
    ien_nxt  = ien_q;
    if (set_we) ien_nxt = ien_nxt | wbits;
    if (clr_we) ien_nxt = ien_nxt & ~wbits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ien_q  <= '0;
      irq_n  <= 1'b1;
    end else begin
      stat_q <= stat_nxt;
      ien_q  <= ien_nxt;
      irq_n  <= ~|(stat_nxt & ien_nxt);
    end
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev_chk
    AST_W1C: assert property (@(posedge clk) disable iff (rst)
      (stat_we && wbits[g] && !ev[g]) |=> !stat_q[g]); // R9
    AST_EV_SET: assert property (@(posedge clk) disable iff (rst)
      ev[g] |=> stat_q[g]); // R8
  end

  AST_IRQ_AGREE: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(|(stat_q & ien_q))); // R11
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 3,
  parameter int RST_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              wdt_rst_n,
  output logic              irq_n
);
  localparam int PC_W   = $clog2(RST_CYC + 1);
  localparam int EN_BIT = PRE_W + 2;

  logic              we_ctrl, we_load, we_trig, we_run, we_delay;
  logic              we_stat, we_iset, we_iclr;
  logic              pre_en_q;
  logic [PRE_W-1:0]  ratio_q;
  logic              running, cnt_tick, reload, ovf_ev, dly_ev;
  logic [CNT_W-1:0]  count_q, load_q, delay_q, trig_q;
  logic [NUM_EV-1:0] stat_q, ien_q, ev;
  logic [PC_W-1:0]   pulse_q;
  logic [31:0]       rd_nxt;

  always_comb begin
    we_ctrl  = wr_en && (addr == ADDR_W'(RA_CTRL));
    we_load  = wr_en && (addr == ADDR_W'(RA_LOAD));
    we_trig  = wr_en && (addr == ADDR_W'(RA_TRIG));
    we_run   = wr_en && (addr == ADDR_W'(RA_RUN));
    we_delay = wr_en && (addr == ADDR_W'(RA_DELAY));
    we_stat  = wr_en && (addr == ADDR_W'(RA_STAT));
    we_iset  = wr_en && (addr == ADDR_W'(RA_IENSET));
    we_iclr  = wr_en && (addr == ADDR_W'(RA_IENCLR));
    ev          = '0;
    ev[EV_OVF]  = ovf_ev;
    ev[EV_DLY]  = dly_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_en_q <= 1'b0;
      ratio_q  <= '0;
    end else if (we_ctrl) begin
      pre_en_q <= wdata[EN_BIT];
      ratio_q  <= wdata[EN_BIT-1:2];
    end
  end

  wdog_runctl u_run (
    .clk(clk), .rst(rst), .run_we(we_run), .wdata(wdata), .running(running)
  );

  wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tick_en(tick_en), .run(running),
    .clr(we_ctrl || reload), .pre_en(pre_en_q), .ratio(ratio_q),
    .cnt_tick(cnt_tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .load_we(we_load),
    .trig_we(we_trig), .delay_we(we_delay), .wdata(wdata[CNT_W-1:0]),
    .count_q(count_q), .load_q(load_q), .delay_q(delay_q), .trig_q(trig_q),
    .reload(reload), .ovf_ev(ovf_ev), .dly_ev(dly_ev)
  );

  wdog_irq u_irq (
    .clk(clk), .rst(rst), .ev(ev), .stat_we(we_stat), .set_we(we_iset),
    .clr_we(we_iclr), .wbits(wdata[NUM_EV-1:0]), .stat_q(stat_q),
    .ien_q(ien_q), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q   <= '0;
      wdt_rst_n <= 1'b1;
    end else if (ovf_ev) begin
      pulse_q   <= PC_W'(RST_CYC - 1);
      wdt_rst_n <= 1'b0;
    end else if (pulse_q != '0) begin
      pulse_q   <= pulse_q - PC_W'(1);
    end else begin
      wdt_rst_n <= 1'b1;
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (addr)
      ADDR_W'(RA_CTRL):   begin
        rd_nxt[EN_BIT]     = pre_en_q;
        rd_nxt[EN_BIT-1:2] = ratio_q;
      end
      ADDR_W'(RA_COUNT):  rd_nxt[CNT_W-1:0]  = count_q;
      ADDR_W'(RA_LOAD):   rd_nxt[CNT_W-1:0]  = load_q;
      ADDR_W'(RA_TRIG):   rd_nxt[CNT_W-1:0]  = trig_q;
      ADDR_W'(RA_RUN):    rd_nxt[0]          = running;
      ADDR_W'(RA_DELAY):  rd_nxt[CNT_W-1:0]  = delay_q;
      ADDR_W'(RA_STAT):   rd_nxt[NUM_EV-1:0] = stat_q;
      ADDR_W'(RA_IENSET): rd_nxt[NUM_EV-1:0] = ien_q;
      ADDR_W'(RA_IENCLR): rd_nxt[NUM_EV-1:0] = ien_q;
      default:            rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end

  AST_RST_FROM_OVF: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst_n) |-> $past(ovf_ev)); // R7
  AST_RST_HELD: assert property (@(posedge clk) disable iff (rst)
    (!wdt_rst_n && pulse_q != '0) |=> !wdt_rst_n); // R7
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst_n, irq_n;
  int checks = 0;
  int errors = 0;
  logic [31:0] v, c0;

  always #5 clk = ~clk;

  wdog_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .wdt_rst_n(wdt_rst_n), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd(4'd1, v); chk("R1 count", v, 0);
    rd(4'd4, v); chk("R1 running", v, 1);
    rd(4'd6, v); chk("R1 status", v, 0);
    rd(4'd7, v); chk("R1 enables", v, 0);
    chk("R1 wdt_rst_n", {31'b0, wdt_rst_n}, 1);
    chk("R1 irq_n", {31'b0, irq_n}, 1);
  endtask

  task automatic t_count;
    tick(5);
    rd(4'd1, v); chk("R2 five ticks", v, 5);
    tick(1);
    rd(4'd1, v); chk("R2 one more", v, 6);
  endtask

  task automatic t_presc;
    rd(4'd1, c0);
    wr(4'd0, 32'h0000_0028);
    tick(3);
    rd(4'd1, v); chk("R3 div4 three ticks", v, c0);
    tick(1);
    rd(4'd1, v); chk("R3 div4 fourth tick", v, c0 + 1);
    tick(4);
    rd(4'd1, v); chk("R3 div4 eight ticks", v, c0 + 2);
    wr(4'd0, 32'h0000_0020);
    tick(3);
    rd(4'd1, v); chk("R3 field zero", v, c0 + 5);
    wr(4'd0, 32'h0000_001C);
    tick(2);
    rd(4'd1, v); chk("R3 field set, enable clear", v, c0 + 7);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_load_trig;
    rd(4'd1, c0);
    wr(4'd2, 32'h100);
    rd(4'd1, v); chk("R4 load no fly", v, c0);
    tick(1);
    rd(4'd1, v); chk("R4 counts past load", v, c0 + 1);
    wr(4'd3, 32'h1);
    rd(4'd1, v); chk("R5 new trigger reloads", v, 32'h100);
    tick(1);
    wr(4'd3, 32'h1);
    rd(4'd1, v); chk("R5 same trigger ignored", v, 32'h101);
    wr(4'd3, 32'h2);
    rd(4'd1, v); chk("R5 second new trigger", v, 32'h100);
  endtask

  task automatic t_ovf;
    int n;
    wr(4'd2, 32'hFFFF_FFFE);
    wr(4'd3, 32'h3);
    wr(4'd2, 32'h20);
    tick(1);
    chk("R7 no pulse before overflow", {31'b0, wdt_rst_n}, 1);
    tick(1);
    n = 0;
    while (!wdt_rst_n && n < 100) begin n++; @(negedge clk); end
    chk("R7 reset pulse length", n, 16);
    chk("R11 irq off with enables clear", {31'b0, irq_n}, 1);
    rd(4'd1, v); chk("R6 reload on overflow", v, 32'h20);
    rd(4'd6, v); chk("R6 overflow status", v, 1);
  endtask

  task automatic t_delay;
    wr(4'd6, 32'h1);
    rd(4'd6, v); chk("R9 w1c overflow bit", v, 0);
    wr(4'd5, 32'h25);
    tick(4);
    rd(4'd6, v); chk("R8 not yet", v, 0);
    tick(1);
    rd(4'd6, v); chk("R8 delay reached", v, 2);
    wr(4'd6, 32'h0);
    rd(4'd6, v); chk("R9 zero write keeps", v, 2);
    wr(4'd6, 32'h2);
    rd(4'd6, v); chk("R9 w1c delay bit", v, 0);
  endtask

  task automatic t_irq;
    wr(4'd7, 32'h2);
    rd(4'd7, v); chk("R10 set enable", v, 2);
    chk("R11 no event", {31'b0, irq_n}, 1);
    wr(4'd5, 32'h27);
    tick(2);
    chk("R11 enabled event", {31'b0, irq_n}, 0);
    wr(4'd7, 32'h0);
    rd(4'd7, v); chk("R10 zero set no effect", v, 2);
    wr(4'd8, 32'h2);
    chk("R11 after disable", {31'b0, irq_n}, 1);
    rd(4'd8, v); chk("R10 clear enable", v, 0);
    wr(4'd7, 32'h1);
    chk("R11 other enable only", {31'b0, irq_n}, 1);
    wr(4'd7, 32'h2);
    chk("R11 reenable", {31'b0, irq_n}, 0);
    wr(4'd6, 32'h2);
    chk("R11 status cleared", {31'b0, irq_n}, 1);
    wr(4'd8, 32'h3);
    rd(4'd7, v); chk("R10 clear both", v, 0);
  endtask

  task automatic t_run;
    rd(4'd1, c0);
    wr(4'd4, 32'hAAAA); wr(4'd4, 32'h1234);
    rd(4'd4, v); chk("R12 bad stop abandoned", v, 1);
    tick(1);
    rd(4'd1, v); chk("R12 still counting", v, c0 + 1);
    wr(4'd4, 32'hAAAA); wr(4'd4, 32'h5555);
    rd(4'd4, v); chk("R12 stopped", v, 0);
    tick(3);
    rd(4'd1, v); chk("R12 ticks ignored when stopped", v, c0 + 1);
    wr(4'd4, 32'hBBBB); wr(4'd4, 32'h4444);
    rd(4'd4, v); chk("R12 restarted", v, 1);
    tick(1);
    rd(4'd1, v); chk("R12 counts after start", v, c0 + 2);
    wr(4'd4, 32'hBBBB); wr(4'd4, 32'h5555);
    rd(4'd4, v); chk("R12 mixed sequence no stop", v, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_presc();
    t_load_trig();
    t_ovf();
    t_delay();
    t_irq();
    t_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule